// File: doc/BRIEF.md
# BPSK Subcarrier Response Framer

This block turns a short byte buffer into the phase-control stream for a tag's load modulator. When the start strobe arrives, it waits a fixed lead-in. It then sends a three-segment start pattern, and after that each byte as an asynchronous character: a start bit, eight data bits, a stop bit and a guard bit. If enabled, a 16-bit checksum follows as two more characters. The frame closes with a coded end pattern, after which modulation stops.

Time is counted in half bit-times, so the block can express a phase flip in the middle of a bit. An external `half_tick` pulse marks each half bit-time. The output `phase` selects the subcarrier phase for the current half bit-time. The block supports two codings. In level coding, the phase follows the bit value. In transition coding, the phase flips in the middle of every 1 and at the start of a 0 that follows a 0. Carrier and subcarrier generation are outside the block.

Top module: `bpsk_resp_framer`

## Requirements
- R1: After reset, `busy`, `mod_on` and `phase` are all 0.
- R2: A `start` pulse while idle latches `nbytes`, `crc_en` and `miller`, and `busy` is 1 on the next clock. A `start` while `busy` is 1 has no effect on the frame being sent.
- R3: For the first 24 `half_tick` pulses after a start (12 bit-times), `mod_on` and `phase` stay 0. `mod_on` rises on the 24th pulse.
- R4: The start pattern is 44 half-slots long: 20 at phase 0, then 20 at phase 1, then 4 at phase 0.
- R5: Each character is a 0 start bit, eight data bits with the least significant bit first, a 1 stop bit and a 1 guard bit. Data bytes go out in index order, and byte k is `buf_data[8k+7:8k]`.
- R6: With `miller`=0, both halves of every coded bit carry phase equal to the inverse of the bit. The phase therefore flips on every value change, including from the start pattern into the first start bit.
- R7: With `miller`=1, a 1 keeps the incoming phase for its first half and flips at mid-bit. A 0 after a 1 keeps the phase. A 0 after a 0 flips at the start of the bit. The start pattern counts as ending on a 1, so there is no flip into the first start bit.
- R8: With `crc_en`=1, two extra characters follow the data, low byte first. The checksum starts at 0xFFFF, uses the polynomial x^16+x^12+x^5+1 processed least significant bit first (shift right, XOR 0x8408), covers the data bits only and has no final inversion.
- R9: With `crc_en`=0, the end pattern follows the last data character directly.
- R10: The end pattern is ten coded 0 bits, then two coded 1 bits, in the selected coding. On the half-tick that ends it, `busy` and `mod_on` fall and `phase` returns to 0.
- R11: `phase` changes only on clock edges where `half_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame when idle |
| half_tick | input | 1 | One-cycle pulse per half bit-time |
| crc_en | input | 1 | Append checksum characters |
| miller | input | 1 | 1 selects transition coding, 0 selects level coding |
| nbytes | input | $clog2(MAX_BYTES+1) | Number of data bytes, 1 to MAX_BYTES |
| buf_data | input | 8*MAX_BYTES | Byte buffer, byte 0 in the low bits, held stable while busy |
| phase | output | 1 | Subcarrier phase for the current half bit-time |
| mod_on | output | 1 | Subcarrier modulation active |
| busy | output | 1 | Frame in progress, from start until modulation stops |

## Verification
The bench sweeps both codings, with the checksum on and off, four buffer lengths including the maximum, and four data patterns. It compares every half-slot against a model built from the bit list. The all-zero and all-one patterns drive transition coding through long runs of its previous-bit rule. A design that flipped, or failed to flip, on a 0 after a 0 would drift by one phase for the rest of the frame.

The boundary from the start pattern into the first start bit is checked in both codings, since level coding must flip there and transition coding must not. The last lead-in slot, the checksum byte order and the exact half-tick on which modulation stops are also checked. An off-by-one counter, or CRC bytes sent high byte first, shows up as a length or value mismatch. A mid-frame start with a different configuration must leave the stream untouched.

// File: rtl/bpsk_resp_framer.sv
module bpsk_resp_framer #(
  parameter int MAX_BYTES     = 8,
  parameter int LEAD_BITS     = 12,
  parameter int SOT_LOW_BITS  = 10,
  parameter int SOT_HIGH_BITS = 10,
  parameter int SOT_TAIL_BITS = 2,
  parameter int EOT_ZERO_BITS = 10,
  parameter int EOT_ONE_BITS  = 2,
  localparam int NB_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   half_tick,
  input  logic                   crc_en,
  input  logic                   miller,
  input  logic [NB_W-1:0]        nbytes,
  input  logic [8*MAX_BYTES-1:0] buf_data,
  output logic                   phase,
  output logic                   mod_on,
  output logic                   busy
);

  localparam int SOT_BITS = SOT_LOW_BITS + SOT_HIGH_BITS + SOT_TAIL_BITS;
  localparam int EOT_BITS = EOT_ZERO_BITS + EOT_ONE_BITS;
  localparam int MAX_AB   = (LEAD_BITS > SOT_BITS) ? LEAD_BITS : SOT_BITS;
  localparam int CNT_MAX  = (MAX_AB > EOT_BITS) ? MAX_AB : EOT_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int IDX_W    = $clog2(MAX_BYTES + 2);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SOT, S_BODY, S_EOT} st_t;

  st_t              st;
  logic             h;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bi;
  logic [3:0]       si;
  logic [15:0]      crc;
  logic             prev_bit, prev_end;
  logic             cfg_miller, cfg_crc;
  logic [IDX_W-1:0] cfg_n;

  logic [IDX_W-1:0] total;
  logic [7:0]       data_byte, cur_byte;
  logic [3:0]       si_m1;
  logic             body_bit, cur_bit, ref_ph, end_ph, coded, sot_ph;
  logic             crc_bit_slot;

  assign total = cfg_n + (cfg_crc ? IDX_W'(2) : '0);

  always_comb begin
    data_byte = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (bi == IDX_W'(k)) data_byte = buf_data[8*k +: 8];
  end

  assign cur_byte = (bi < cfg_n) ? data_byte : ((bi == cfg_n) ? crc[7:0] : crc[15:8]);
  assign si_m1    = si - 4'd1;
  assign body_bit = (si == 4'd0) ? 1'b0 : ((si <= 4'd8) ? cur_byte[si_m1[2:0]] : 1'b1);
  assign cur_bit  = (st == S_BODY) ? body_bit :
                    (st == S_EOT)  ? (cnt >= CNT_W'(EOT_ZERO_BITS)) : 1'b1;

  assign ref_ph = cfg_miller ? ((!cur_bit && !prev_bit) ? !prev_end : prev_end) : !cur_bit;
  assign end_ph = ref_ph ^ (cfg_miller & cur_bit);
  assign coded  = ref_ph ^ (cfg_miller & cur_bit & h);
  assign sot_ph = (cnt >= CNT_W'(SOT_LOW_BITS)) &&
                  (cnt < CNT_W'(SOT_LOW_BITS + SOT_HIGH_BITS));

  assign crc_bit_slot = (st == S_BODY) && (si != 4'd0) && (si <= 4'd8) && (bi < cfg_n);

  assign mod_on = (st == S_SOT) || (st == S_BODY) || (st == S_EOT);
  assign busy   = (st != S_IDLE);
  assign phase  = (st == S_SOT) ? sot_ph :
                  ((st == S_BODY) || (st == S_EOT)) ? coded : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      h          <= 1'b0;
      cnt        <= '0;
      bi         <= '0;
      si         <= '0;
      crc        <= 16'hFFFF;
      prev_bit   <= 1'b1;
      prev_end   <= 1'b0;
      cfg_miller <= 1'b0;
      cfg_crc    <= 1'b0;
      cfg_n      <= '0;
    end else if (st == S_IDLE) begin
      if (start) begin
        st         <= S_LEAD;
        h          <= 1'b0;
        cnt        <= '0;
        crc        <= 16'hFFFF;
        cfg_miller <= miller;
        cfg_crc    <= crc_en;
        cfg_n      <= IDX_W'(nbytes);
      end
    end else if (half_tick) begin
      if (!h) begin
        h <= 1'b1;
      end else begin
        h <= 1'b0;
        unique case (st)
          S_LEAD: begin
            if (cnt == CNT_W'(LEAD_BITS - 1)) begin
              st  <= S_SOT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_SOT: begin
            if (cnt == CNT_W'(SOT_BITS - 1)) begin
              st       <= S_BODY;
              bi       <= '0;
              si       <= '0;
              prev_bit <= 1'b1;
              prev_end <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          S_BODY: begin
            prev_bit <= cur_bit;
            prev_end <= end_ph;
            if (crc_bit_slot)
              crc <= {1'b0, crc[15:1]} ^ ((crc[0] ^ cur_bit) ? 16'h8408 : 16'h0000);
            if (si == 4'd10) begin
              si <= '0;
              if (bi == total - 1'b1) begin
                st  <= S_EOT;
                cnt <= '0;
              end else bi <= bi + 1'b1;
            end else si <= si + 4'd1;
          end
          S_EOT: begin
            prev_bit <= cur_bit;
            prev_end <= end_ph;
            if (cnt == CNT_W'(EOT_BITS - 1)) st <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R11
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(phase));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cfg_miller) && $stable(cfg_crc) && $stable(cfg_n)));

  // R3
  mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_on) |-> ($past(half_tick) && busy));

  // R10
  mod_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_on) |-> (!busy && !phase));

endmodule

// File: tb/test_bpsk_resp_framer.sv
module test_bpsk_resp_framer;
  localparam int MAX_BYTES = 8;
  localparam int NB_W = $clog2(MAX_BYTES + 1);

  logic clk = 0, rst_n = 0, start = 0, half_tick = 0, crc_en = 0, miller = 0;
  logic [NB_W-1:0] nbytes = '0;
  logic [8*MAX_BYTES-1:0] buf_data = '0;
  logic phase, mod_on, busy;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic exp_ph [0:1023];
  int exp_len;

  always #10 clk = ~clk;

  bpsk_resp_framer #(.MAX_BYTES(MAX_BYTES)) i_bpsk_resp_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .half_tick(half_tick),
    .crc_en(crc_en), .miller(miller), .nbytes(nbytes), .buf_data(buf_data),
    .phase(phase), .mod_on(mod_on), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic build_exp(input int n, input bit c, input bit m);
    logic bits [0:255];
    int nb = 0;
    logic [15:0] crc = 16'hFFFF;
    logic [7:0] byt;
    logic pb, pe, rf;
    exp_len = 0;
    for (int k = 0; k < 22; k++) begin
      exp_ph[exp_len] = (k >= 10 && k < 20);
      exp_ph[exp_len+1] = (k >= 10 && k < 20);
      exp_len += 2;
    end
    for (int b = 0; b < n + (c ? 2 : 0); b++) begin
      if (b < n) byt = buf_data[8*b +: 8];
      else if (b == n) byt = crc[7:0];
      else byt = crc[15:8];
      bits[nb++] = 1'b0;
      for (int i = 0; i < 8; i++) begin
        bits[nb++] = byt[i];
        if (b < n) crc = {1'b0, crc[15:1]} ^ ((crc[0] ^ byt[i]) ? 16'h8408 : 16'h0000);
      end
      bits[nb++] = 1'b1;
      bits[nb++] = 1'b1;
    end
    for (int k = 0; k < 12; k++) bits[nb++] = (k >= 10);
    pb = 1'b1; pe = 1'b0;
    for (int k = 0; k < nb; k++) begin
      if (!m) begin
        exp_ph[exp_len] = !bits[k];
        exp_ph[exp_len+1] = !bits[k];
      end else begin
        rf = (!bits[k] && !pb) ? !pe : pe;
        exp_ph[exp_len] = rf;
        exp_ph[exp_len+1] = rf ^ bits[k];
        pe = rf ^ bits[k];
        pb = bits[k];
      end
      exp_len += 2;
    end
  endtask

  task automatic tick(output logic ph_s);
    @(negedge clk) half_tick = 1;
    @(negedge clk) half_tick = 0;
    @(negedge clk) ph_s = phase;
    @(negedge clk);
    // R11: no change between half ticks
    check(phase == ph_s, "R11", phase, ph_s);
  endtask

  task automatic run_frame(input int n, input bit c, input bit m, input int pat, input bit inject);
    logic ph;
    string tag;
    int eot_start;
    for (int b = 0; b < MAX_BYTES; b++) begin
      case (pat)
        0: buf_data[8*b +: 8] = 8'h00;
        1: buf_data[8*b +: 8] = 8'hFF;
        2: buf_data[8*b +: 8] = 8'h5A;
        default: buf_data[8*b +: 8] = 8'((b * 37 + 13 + n) & 255);
      endcase
    end
    build_exp(n, c, m);
    eot_start = exp_len - 24;
    @(negedge clk);
    nbytes = NB_W'(n); crc_en = c; miller = m; start = 1;
    @(negedge clk) start = 0;
    check(busy == 1 && mod_on == 0, "R2", busy, 1);
    for (int i = 1; i <= 24; i++) begin
      tick(ph);
      if (i < 24) check(mod_on == 0 && ph == 0 && busy == 1, "R3", mod_on, 0);
      else check(mod_on == 1 && ph == exp_ph[0], "R3", mod_on, 1);
    end
    for (int j = 1; j < exp_len; j++) begin
      tick(ph);
      if (j < 44) tag = "R4";
      else if (j >= eot_start) tag = "R10";
      else if (c && j >= eot_start - 44) tag = "R8";
      else tag = m ? "R7" : "R6";
      check(ph == exp_ph[j] && mod_on == 1, tag, ph, exp_ph[j]);
      if (j == 44) check(ph == exp_ph[j], "R5", ph, exp_ph[j]);
      if (inject && j == 120) begin
        // R2: start while busy is ignored
        @(negedge clk);
        start = 1; miller = !m; crc_en = !c; nbytes = NB_W'(1);
        @(negedge clk);
        start = 0; miller = m; crc_en = c; nbytes = NB_W'(n);
      end
    end
    tick(ph);
    check(busy == 0 && mod_on == 0 && ph == 0, c ? "R10" : "R9", busy, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int ns [4] = '{1, 2, 5, 8};
    repeat (3) @(negedge clk);
    // R1
    check(busy == 0 && mod_on == 0 && phase == 0, "R1", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && mod_on == 0 && phase == 0, "R1", phase, 0);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int ni = 0; ni < 4; ni++)
          for (int p = 0; p < 4; p++)
            run_frame(ns[ni], c[0], m[0], p, (ni == 3 && p == 3));
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule